// File: doc/BRIEF.md
# External Interrupt Combiner and Latch

This block merges four active-high port interrupt inputs and one dedicated active-low interrupt pin into a single external interrupt source. All five inputs are first passed through a two-flop synchronizer. The block then detects the moment the merged source goes from fully inactive to active, and records that moment in a pending flag. Once any input is active, every other input is masked until all of them are inactive again. A new request therefore needs a complete quiet period followed by a fresh activation.

One 8-bit control/status register at address 0x0D holds four things: an enable bit, the read-only pending flag, a write-one-to-clear bit and two oscillator-select bits. The oscillator-select bits are only passed out to the clock logic. A configuration strap chooses between two modes. In edge-only mode the CPU request follows the pending flag alone. In edge-and-level mode the request also stays high for as long as the merged source stays active.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0xC0 (enable bit 7 = 1, oscillator-select bit 6 = 1, bit 5 = 0, pending bit 3 = 0), `osc_sel_o` is 2'b10 ({bit 6, bit 5}) and `irq_req_o` is 0.
- R2: In edge-only mode (`level_mode_i` = 0), a port input going high while all sources are inactive sets the pending flag (bit 3), and `irq_req_o` rises when the enable bit is 1.
- R3: Once a request has been latched, no further request is latched until every source has been inactive and then one becomes active again.
- R4: While any source is active, activity on the other sources (a port input rising or the pin falling) latches nothing. Releasing some of the active sources while others stay active also latches nothing.
- R5: A falling level on the active-low interrupt pin, with all port inputs low, latches a request.
- R6: With the enable bit at 0, `irq_req_o` stays 0 but the pending flag still latches. Setting the enable bit to 1 then raises `irq_req_o` at once.
- R7: Bits 4, 2 and 0 always read 0. Any address other than 0x0D reads 0x00, and a write to another address leaves the register unchanged. Bits 7, 6 and 5 are read/write.
- R8: Writing 1 to bit 1 of the register clears the pending flag. Bit 1 always reads 0. Writing 0 to bit 1 leaves the flag unchanged.
- R9: If a new request is latched in the same cycle as a clear write, the pending flag ends up set.
- R10: In edge-and-level mode (`level_mode_i` = 1), `irq_req_o` stays high while the merged source is active, even after the flag is cleared. In edge-only mode, `irq_req_o` is 0 whenever the flag is 0.
- R11: Input pins pass through a two-stage synchronizer. In edge-and-level mode, `irq_req_o` is still 0 one clock edge after a port input rises and is 1 after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_irq_i | input | 4 | Port interrupt inputs, active high |
| ext_n_i | input | 1 | Dedicated interrupt pin, active low |
| level_mode_i | input | 1 | Mode strap: 0 = edge only, 1 = edge and level |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0x00 unless the address is 0x0D |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| osc_sel_o | output | 2 | Oscillator-select bits {bit 6, bit 5} |

## Verification
The assertions check these rules on every cycle:
- a detected activation never lasts two cycles in a row;
- the pending flag only rises after an activation;
- a clear that coincides with an activation leaves the flag set;
- a disabled enable bit always silences the request;
- edge-only mode never requests without the flag;
- the unused read bits stay zero.

Other behaviour can only be shown by the bench's scenarios: that the masking rules between the port inputs and the pin hold while sources are overlapped and released one by one, the exact two-stage synchronizer latency, and the different request behaviour of the two modes after a clear.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_EN     = 7;
  localparam int BIT_OSC_HI = 6;
  localparam int BIT_OSC_LO = 5;
  localparam int BIT_PEND   = 3;
  localparam int BIT_CLR    = 1;
  localparam logic [1:0] OSC_RST = 2'b10;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_combine.sv
module eirq_combine #(
  parameter int NUM_PORT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PORT-1:0] port_s_i,
  input  logic                ext_n_s_i,
  output logic                active_o,
  output logic                edge_o
);
  logic active_q;

  // Any active source holds the merged line; a new edge needs all sources idle first.
  assign active_o = (|port_s_i) | ~ext_n_s_i;
  assign edge_o   = active_o & ~active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_o;
  end

  // R4
  edge_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/eirq_csr.sv
module eirq_csr
  import eirq_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h0D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              edge_i,
  input  logic              active_i,
  input  logic              level_mode_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_req_o,
  output logic [1:0]        osc_sel_o
);
  logic       hit, wr, clr;
  logic       en_q, pend_q;
  logic [1:0] osc_q;

  assign hit = (addr_i == CSR_ADDR);
  assign wr  = hit & wr_en_i;
  assign clr = wr & wdata_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      osc_q <= OSC_RST;
    end else if (wr) begin
      en_q  <= wdata_i[BIT_EN];
      osc_q <= {wdata_i[BIT_OSC_HI], wdata_i[BIT_OSC_LO]};
    end
  end

  // Set wins over clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (edge_i) pend_q <= 1'b1;
    else if (clr)    pend_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[BIT_EN]     = en_q;
      rdata_o[BIT_OSC_HI] = osc_q[1];
      rdata_o[BIT_OSC_LO] = osc_q[0];
      rdata_o[BIT_PEND]   = pend_q;
    end
  end

  assign irq_req_o = en_q & (pend_q | (level_mode_i & active_i));
  assign osc_sel_o = osc_q;

  // R2
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(edge_i));
  // R9
  clr_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && edge_i) |=> pend_q);
  // R6
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_req_o);
  // R10
  edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i && !pend_q) |-> !irq_req_o);
  // R7
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[4] == 1'b0) && (rdata_o[2] == 1'b0) && (rdata_o[BIT_CLR] == 1'b0) && (rdata_o[0] == 1'b0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int                NUM_PORT    = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR    = 8'h0D
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PORT-1:0] port_irq_i,
  input  logic                ext_n_i,
  input  logic                level_mode_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic                irq_req_o,
  output logic [1:0]          osc_sel_o
);
  localparam int SYNC_W = NUM_PORT + 1;

  logic [SYNC_W-1:0] pins_s;
  logic              active, edge_det;

  // Port inputs idle low, pin idles high.
  eirq_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, {NUM_PORT{1'b0}}})
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_n_i, port_irq_i}),
    .q_o   (pins_s)
  );

  eirq_combine #(.NUM_PORT(NUM_PORT)) i_combine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_s_i (pins_s[NUM_PORT-1:0]),
    .ext_n_s_i(pins_s[NUM_PORT]),
    .active_o (active),
    .edge_o   (edge_det)
  );

  eirq_csr #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) i_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .edge_i      (edge_det),
    .active_i    (active),
    .level_mode_i(level_mode_i),
    .rdata_o     (rdata_o),
    .irq_req_o   (irq_req_o),
    .osc_sel_o   (osc_sel_o)
  );
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] port_irq = 4'h0;
  logic       ext_n = 1'b1;
  logic       level_mode = 1'b0;
  logic [7:0] addr = 8'h0D;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_req;
  logic [1:0] osc_sel;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq;
    logic [1:0] osc;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .port_irq_i  (port_irq),
    .ext_n_i     (ext_n),
    .level_mode_i(level_mode),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .irq_req_o   (irq_req),
    .osc_sel_o   (osc_sel)
  );

  task automatic expect_out(string tag, logic [7:0] rd, logic irq, logic [1:0] osc);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.rd = rd; e.irq = irq; e.osc = osc;
    sb_q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h0D;
  endtask

  task automatic set_pins(logic [3:0] p, logic x);
    @(negedge clk);
    port_irq = p; ext_n = x;
  endtask

  // Monitor: compare at every negedge plus 1 ns.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (rdata !== e.rd || irq_req !== e.irq || osc_sel !== e.osc) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq=%b osc=%b expected rdata=%h irq=%b osc=%b",
                   e.tag, rdata, irq_req, osc_sel, e.rd, e.irq, e.osc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all: watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    // R1 reset state
    expect_out("R1", 8'hC0, 1'b0, 2'b10);
    // R7 other address reads zero, write elsewhere ignored
    @(negedge clk); addr = 8'h0C;
    expect_out("R7", 8'h00, 1'b0, 2'b10);
    @(negedge clk); addr = 8'h0D;
    write_reg(8'h0C, 8'h00);
    expect_out("R7", 8'hC0, 1'b0, 2'b10);
    // R2 port edge latches
    set_pins(4'b0001, 1'b1); wait_cyc(3);
    expect_out("R2", 8'hC8, 1'b1, 2'b10);
    // R8 clear, bit 1 reads 0
    write_reg(8'h0D, 8'hC2);
    expect_out("R8", 8'hC0, 1'b0, 2'b10);
    // R3 held high: no re-latch
    wait_cyc(3);
    expect_out("R3", 8'hC0, 1'b0, 2'b10);
    // R4 masking while a source is active
    set_pins(4'b0101, 1'b0); wait_cyc(3);
    expect_out("R4", 8'hC0, 1'b0, 2'b10);
    set_pins(4'b0100, 1'b0); wait_cyc(3);
    expect_out("R4", 8'hC0, 1'b0, 2'b10);
    set_pins(4'b0000, 1'b0); wait_cyc(3);
    expect_out("R4", 8'hC0, 1'b0, 2'b10);
    set_pins(4'b0000, 1'b1); wait_cyc(3);
    expect_out("R3", 8'hC0, 1'b0, 2'b10);
    // R5 pin falling latches
    set_pins(4'b0000, 1'b0); wait_cyc(3);
    expect_out("R5", 8'hC8, 1'b1, 2'b10);
    write_reg(8'h0D, 8'hC2);
    set_pins(4'b0000, 1'b1); wait_cyc(3);
    // R6 latch while disabled, request on enable
    write_reg(8'h0D, 8'h40);
    set_pins(4'b1000, 1'b1); wait_cyc(3);
    expect_out("R6", 8'h48, 1'b0, 2'b10);
    write_reg(8'h0D, 8'hC0);
    expect_out("R6", 8'hC8, 1'b1, 2'b10);
    set_pins(4'b0000, 1'b1); wait_cyc(3);
    // R7 osc bits rw, unused bits read 0; R8 bit1=0 keeps flag
    write_reg(8'h0D, 8'hB5);
    expect_out("R7", 8'hA8, 1'b1, 2'b01);
    write_reg(8'h0D, 8'hA2);
    expect_out("R8", 8'hA0, 1'b0, 2'b01);
    // R9 clear coincides with new edge
    set_pins(4'b0010, 1'b1);
    @(negedge clk);
    @(negedge clk); addr = 8'h0D; wdata = 8'hA2; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    expect_out("R9", 8'hA8, 1'b1, 2'b01);
    write_reg(8'h0D, 8'hA2);
    expect_out("R8", 8'hA0, 1'b0, 2'b01);
    set_pins(4'b0000, 1'b1); wait_cyc(3);
    // R11 sync latency in level mode
    @(negedge clk); level_mode = 1'b1;
    set_pins(4'b0001, 1'b1);
    expect_out("R11", 8'hA0, 1'b0, 2'b01);
    expect_out("R11", 8'hA0, 1'b1, 2'b01);
    // R10 level mode holds request after clear
    wait_cyc(3);
    expect_out("R10", 8'hA8, 1'b1, 2'b01);
    write_reg(8'h0D, 8'hA2);
    expect_out("R10", 8'hA0, 1'b1, 2'b01);
    set_pins(4'b0000, 1'b1); wait_cyc(3);
    expect_out("R10", 8'hA0, 1'b0, 2'b01);
    @(negedge clk); level_mode = 1'b0;
    wait_cyc(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule